// File: doc/BRIEF.md
# Protection Error Capture Registers

This block is the status and fault-logging register set of a memory protection unit that watches several bus slave ports. Each slave port has its own access evaluator outside this block. When that evaluator denies an access, it raises a one-cycle error strobe together with the faulting address, a per-descriptor denial vector, the process ID, the master number, the access attributes and the access direction. The block stores these values in that port's own error address and error detail registers. It also sets a sticky error flag for the port. Each port keeps only its latest fault.

Software reads and writes the registers one 32-bit word at a time. The interface has a word index, a write strobe and write data, and read data that follows the index combinationally. The control word holds four things: the global protection enable, which resets to 1; read-only counts of ports and descriptors; and the per-port error flags, which are cleared by writing 1. While the enable bit is 0, every access is allowed and error strobes are ignored. The global enable is also driven on an output port, so the evaluators can follow it.

Top module: `prot_err_capture`

## Requirements
- R1: After reset the enable bit is 1, every flag is 0 and every error address and detail register is 0. With the default parameters, word index 0 reads 0x0000_1051.
- R2: Suppose errValid[n] is high at a rising edge while the enable is 1. From that edge on, the flag of port n is set and word index 1+2n holds errAddr[n]. The flag of port n sits at control bit 32-NUM_PORTS+n, which is bit 27+n with five ports.
- R3: Word index 2+2n holds the detail of port n's last fault. Bits [31:16] are the descriptor denial vector. Bits [15:8] are the process ID and bits [7:4] are the master number. Bit 3 is 1 for supervisor mode and bit 2 is 1 for a data access; these come from errAttr[n][1] and errAttr[n][0]. Bit 0 is 1 for a write. Bit 1 reads 0.
- R4: A later fault on the same port replaces both the address and the detail of the earlier one. The flag stays set.
- R5: A write to index 0 clears exactly the flags whose bits are written as 1. Flags whose bits are written as 0 keep their value.
- R6: If a port captures a fault in the same cycle that software clears its flag, the flag ends up set and the new fault is stored.
- R7: Faults on several ports in the same cycle are each stored into their own port's registers.
- R8: Writing bit 0 of index 0 sets the enable, which is also driven on protEnable. While the enable is 0, error strobes change no flag and no error register.
- R9: Writes to the error address and detail registers have no effect. Word indices above 2*NUM_PORTS read 0.
- R10: Control bits [7:4] report NUM_PORTS and bits [15:8] report NUM_DESC. Writes do not change these fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regIdx | input | IDX_W | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data of the indexed word |
| errValid | input | NUM_PORTS | Per-port denied-access strobe |
| errAddr | input | NUM_PORTS x 32 | Faulting address per port |
| errDesc | input | NUM_PORTS x NUM_DESC | Per-descriptor denial vector per port |
| errPid | input | NUM_PORTS x 8 | Process ID of the faulting access |
| errMaster | input | NUM_PORTS x 4 | Master number of the faulting access |
| errAttr | input | NUM_PORTS x 2 | Attributes: [1] supervisor, [0] data access |
| errWrite | input | NUM_PORTS | Direction: 1 write, 0 read |
| protEnable | output | 1 | Global protection enable |
| portErrFlags | output | NUM_PORTS | Sticky per-port error flags |

## Verification
The bench builds the block with its defaults: five ports and sixteen descriptors. With these values the flags fill control bits 27 to 31 exactly, and the detail word carries a full 16-bit denial vector. This lets the bench drive fault patterns on the highest port and with every descriptor bit set. It also exercises faults on two ports in the same cycle, a fault landing in the same cycle as a clear, and the word indices left unused above the last port.

// File: rtl/prot_err_pkg.sv
package prot_err_pkg;

  parameter int MAX_PORTS  = 8;
  parameter int REG_W      = 32;
  parameter int PID_W      = 8;
  parameter int MASTER_W   = 4;
  parameter int ATTR_W     = 2;
  parameter int VEC_FIELD_W = 16;

  // Control word field positions
  localparam int EN_BIT      = 0;
  localparam int NPORT_LSB   = 4;
  localparam int NPORT_W     = 4;
  localparam int NDESC_LSB   = 8;
  localparam int NDESC_W     = 8;

  // Detail word field positions
  localparam int DET_WR_BIT   = 0;
  localparam int DET_ATTR_LSB = 2;
  localparam int DET_MST_LSB  = 4;
  localparam int DET_PID_LSB  = 8;
  localparam int DET_VEC_LSB  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic [MAX_PORTS-1:0] capMask;
    logic [MAX_PORTS-1:0] clrMask;
    logic                 enWr;
    logic                 enVal;
  } strobe_t;

endpackage

// File: rtl/prot_err_ctrl.sv
module prot_err_ctrl
  import prot_err_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int IDX_W     = 4
) (
  input  logic [IDX_W-1:0]     regIdx,
  input  logic                 regWrEn,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [NUM_PORTS-1:0] errValid,
  input  logic                 enableIn,
  output strobe_t              strobe
);

  localparam int FLAG_LSB = REG_W - NUM_PORTS;

  logic ctrlWrite;

  assign ctrlWrite = regWrEn && (regIdx == '0);

  always_comb begin
    strobe = '0;
    strobe.enWr  = ctrlWrite;
    strobe.enVal = regWrData[EN_BIT];
    for (int n = 0; n < NUM_PORTS; n++) begin
      // Write-1-to-clear of each port flag
      strobe.clrMask[n] = ctrlWrite && regWrData[FLAG_LSB+n];
      // Capture only while protection is enabled (R8)
      strobe.capMask[n] = errValid[n] && enableIn;
    end
  end

endmodule

// File: rtl/prot_err_datapath.sv
module prot_err_datapath
  import prot_err_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_DESC  = 16,
  parameter int IDX_W     = 4
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  strobe_t                                strobe,
  input  logic [IDX_W-1:0]                       regIdx,
  input  logic [NUM_PORTS-1:0][REG_W-1:0]        errAddr,
  input  logic [NUM_PORTS-1:0][NUM_DESC-1:0]     errDesc,
  input  logic [NUM_PORTS-1:0][PID_W-1:0]        errPid,
  input  logic [NUM_PORTS-1:0][MASTER_W-1:0]     errMaster,
  input  logic [NUM_PORTS-1:0][ATTR_W-1:0]       errAttr,
  input  logic [NUM_PORTS-1:0]                   errWrite,
  output logic [REG_W-1:0]                       rdData,
  output logic                                   enableOut,
  output logic [NUM_PORTS-1:0]                   flagsOut
);

  localparam int FLAG_LSB = REG_W - NUM_PORTS;

  logic                            enableQ;
  logic [NUM_PORTS-1:0]            flagQ;
  logic [NUM_PORTS-1:0][REG_W-1:0] addrQ;
  logic [NUM_PORTS-1:0][REG_W-1:0] detailQ;
  logic [REG_W-1:0]                ctrlWord;

  // Global enable, resets to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            enableQ <= 1'b1;
    else if (strobe.enWr) enableQ <= strobe.enVal;
  end

  a_r8_enable_held: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enWr |=> $stable(enableQ));

  genvar n;
  generate
    for (n = 0; n < NUM_PORTS; n++) begin : gPort
      logic [REG_W-1:0] detailNext;

      always_comb begin
        detailNext = '0;
        detailNext[DET_VEC_LSB +: VEC_FIELD_W]  = VEC_FIELD_W'(errDesc[n]);
        detailNext[DET_PID_LSB +: PID_W]        = errPid[n];
        detailNext[DET_MST_LSB +: MASTER_W]     = errMaster[n];
        detailNext[DET_ATTR_LSB +: ATTR_W]      = errAttr[n];
        detailNext[DET_WR_BIT]                  = errWrite[n];
      end

      // Sticky flag: set has priority over clear (R6)
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     flagQ[n] <= 1'b0;
        else if (strobe.capMask[n])    flagQ[n] <= 1'b1;
        else if (strobe.clrMask[n])    flagQ[n] <= 1'b0;
      end

      // Most recent fault only
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          addrQ[n]   <= '0;
          detailQ[n] <= '0;
        end else if (strobe.capMask[n]) begin
          addrQ[n]   <= errAddr[n];
          detailQ[n] <= detailNext;
        end
      end

      a_r2_flag_set: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capMask[n] |=> flagQ[n]);

      a_r2_addr_captured: assert property (@(posedge clk) disable iff (!rstN)
        strobe.capMask[n] |=> addrQ[n] == $past(errAddr[n]));

      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rstN)
        (strobe.capMask[n] && strobe.clrMask[n]) |=> flagQ[n]);

      a_r5_flag_held: assert property (@(posedge clk) disable iff (!rstN)
        (!strobe.capMask[n] && !strobe.clrMask[n]) |=> $stable(flagQ[n]));

      a_r9_regs_held: assert property (@(posedge clk) disable iff (!rstN)
        !strobe.capMask[n] |=> ($stable(addrQ[n]) && $stable(detailQ[n])));
    end
  endgenerate

  always_comb begin
    ctrlWord = '0;
    ctrlWord[EN_BIT]                  = enableQ;
    ctrlWord[NPORT_LSB +: NPORT_W]    = NPORT_W'(NUM_PORTS);
    ctrlWord[NDESC_LSB +: NDESC_W]    = NDESC_W'(NUM_DESC);
    ctrlWord[FLAG_LSB +: NUM_PORTS]   = flagQ;
  end

  // Read mux: 0 control, 1+2n address, 2+2n detail
  always_comb begin
    rdData = '0;
    if (regIdx == '0) rdData = ctrlWord;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (regIdx == IDX_W'(1 + 2*p)) rdData = addrQ[p];
      if (regIdx == IDX_W'(2 + 2*p)) rdData = detailQ[p];
    end
  end

  assign enableOut = enableQ;
  assign flagsOut  = flagQ;

endmodule

// File: rtl/prot_err_capture.sv
module prot_err_capture
  import prot_err_pkg::*;
#(
  parameter int NUM_PORTS = 5,
  parameter int NUM_DESC  = 16,
  localparam int IDX_W    = $clog2(2*NUM_PORTS + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [IDX_W-1:0]                   regIdx,
  input  logic                               regWrEn,
  input  logic [31:0]                        regWrData,
  output logic [31:0]                        regRdData,
  input  logic [NUM_PORTS-1:0]               errValid,
  input  logic [NUM_PORTS-1:0][31:0]         errAddr,
  input  logic [NUM_PORTS-1:0][NUM_DESC-1:0] errDesc,
  input  logic [NUM_PORTS-1:0][7:0]          errPid,
  input  logic [NUM_PORTS-1:0][3:0]          errMaster,
  input  logic [NUM_PORTS-1:0][1:0]          errAttr,
  input  logic [NUM_PORTS-1:0]               errWrite,
  output logic                               protEnable,
  output logic [NUM_PORTS-1:0]               portErrFlags
);

  strobe_t strobe;
  logic    enable;

  prot_err_ctrl #(.NUM_PORTS(NUM_PORTS), .IDX_W(IDX_W)) uCtrl (
    .regIdx    (regIdx),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .errValid  (errValid),
    .enableIn  (enable),
    .strobe    (strobe)
  );

  prot_err_datapath #(.NUM_PORTS(NUM_PORTS), .NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .regIdx    (regIdx),
    .errAddr   (errAddr),
    .errDesc   (errDesc),
    .errPid    (errPid),
    .errMaster (errMaster),
    .errAttr   (errAttr),
    .errWrite  (errWrite),
    .rdData    (regRdData),
    .enableOut (enable),
    .flagsOut  (portErrFlags)
  );

  assign protEnable = enable;

endmodule

// File: tb/tb_prot_err_capture.sv
module tb_prot_err_capture;

  localparam int NP = 5;
  localparam int ND = 16;
  localparam int IW = $clog2(2*NP + 1);

  logic                  clk = 1'b0;
  logic                  rstN = 1'b0;
  logic [IW-1:0]         regIdx = '0;
  logic                  regWrEn = 1'b0;
  logic [31:0]           regWrData = '0;
  logic [31:0]           regRdData;
  logic [NP-1:0]         errValid = '0;
  logic [NP-1:0][31:0]   errAddr = '0;
  logic [NP-1:0][ND-1:0] errDesc = '0;
  logic [NP-1:0][7:0]    errPid = '0;
  logic [NP-1:0][3:0]    errMaster = '0;
  logic [NP-1:0][1:0]    errAttr = '0;
  logic [NP-1:0]         errWrite = '0;
  logic                  protEnable;
  logic [NP-1:0]         portErrFlags;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  prot_err_capture #(.NUM_PORTS(NP), .NUM_DESC(ND)) dut (.*);

  typedef struct packed {
    logic [2:0]  port;
    logic [31:0] addr;
    logic [15:0] desc;
    logic [7:0]  pid;
    logic [3:0]  master;
    logic [1:0]  attr;
    logic        wr;
    logic [31:0] expDetail;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{3'd0, 32'h2000_0040, 16'h0000, 8'h11, 4'd0, 2'b11, 1'b1, 32'h0000_110D},
    '{3'd1, 32'h0000_1000, 16'h0004, 8'hA5, 4'd1, 2'b01, 1'b0, 32'h0004_A514},
    '{3'd2, 32'h4000_0000, 16'h0003, 8'h00, 4'd2, 2'b10, 1'b1, 32'h0003_0029},
    '{3'd3, 32'hFFFF_FFE0, 16'h8001, 8'hFF, 4'd4, 2'b00, 1'b0, 32'h8001_FF40},
    '{3'd4, 32'h1FFF_8000, 16'hFFFF, 8'h3C, 4'd7, 2'b11, 1'b1, 32'hFFFF_3C7D},
    '{3'd0, 32'h0800_0004, 16'h0010, 8'h02, 4'd3, 2'b01, 1'b0, 32'h0010_0234}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [31:0] val);
    regIdx = IW'(idx);
    #1;
    val = regRdData;
  endtask

  task automatic writeReg(input int idx, input logic [31:0] val);
    @(negedge clk);
    regIdx = IW'(idx); regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic loadFault(input vec_t v);
    errValid[v.port]  = 1'b1;
    errAddr[v.port]   = v.addr;
    errDesc[v.port]   = v.desc;
    errPid[v.port]    = v.pid;
    errMaster[v.port] = v.master;
    errAttr[v.port]   = v.attr;
    errWrite[v.port]  = v.wr;
  endtask

  task automatic pulseFault(input vec_t v);
    @(negedge clk);
    loadFault(v);
    @(negedge clk);
    errValid = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    vec_t v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    readReg(0, r); check("R1 ctrl word", r, 32'h0000_1051);
    readReg(1, r); check("R1 addr0", r, 32'h0);
    readReg(10, r); check("R1 detail4", r, 32'h0);
    check("R1 protEnable", {31'b0, protEnable}, 32'h1);

    // Vector table: R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      pulseFault(VECS[i]);
      readReg(0, r);
      check("R2 flag", {31'b0, r[27 + VECS[i].port]}, 32'h1);
      readReg(1 + 2*VECS[i].port, r);
      check("R2 addr", r, VECS[i].addr);
      readReg(2 + 2*VECS[i].port, r);
      check("R3 R4 detail", r, VECS[i].expDetail);
    end
    check("R2 flags out", {27'b0, portErrFlags}, 32'h1F);

    // R5 clear all
    writeReg(0, 32'hF800_0001);
    readReg(0, r); check("R5 clear all", r, 32'h0000_1051);

    // R7 two ports in one cycle
    @(negedge clk);
    v = VECS[1]; v.addr = 32'h0000_2220; loadFault(v);
    v = VECS[3]; v.addr = 32'h3333_0000; loadFault(v);
    @(negedge clk);
    errValid = '0;
    readReg(3, r); check("R7 port1 addr", r, 32'h0000_2220);
    readReg(7, r); check("R7 port3 addr", r, 32'h3333_0000);
    readReg(4, r); check("R7 port1 detail", r, 32'h0004_A514);
    readReg(0, r); check("R7 flags", r, 32'h5000_1051);

    // R5 partial clear: port1 written 1, port3 written 0
    writeReg(0, 32'h1000_0001);
    readReg(0, r); check("R5 partial clear", r, 32'h4000_1051);

    // R6 set wins over clear
    @(negedge clk);
    v = VECS[3]; v.addr = 32'h5555_0000; loadFault(v);
    regIdx = '0; regWrData = 32'h4000_0001; regWrEn = 1'b1;
    @(negedge clk);
    errValid = '0; regWrEn = 1'b0;
    readReg(0, r); check("R6 flag kept", r, 32'h4000_1051);
    readReg(7, r); check("R6 addr", r, 32'h5555_0000);

    // R9 read-only error regs, unmapped reads zero
    writeReg(1, 32'hDEAD_BEEF);
    readReg(1, r); check("R9 addr read-only", r, 32'h0800_0004);
    writeReg(2, 32'hDEAD_BEEF);
    readReg(2, r); check("R9 detail read-only", r, 32'h0010_0234);
    readReg(11, r); check("R9 unmapped 11", r, 32'h0);
    readReg(15, r); check("R9 unmapped 15", r, 32'h0);

    // R10 counts read-only
    writeReg(0, 32'h0000_FFF1);
    readReg(0, r); check("R10 counts", r, 32'h4000_1051);

    // R8 disabled: errors ignored
    writeReg(0, 32'h0000_0000);
    check("R8 protEnable low", {31'b0, protEnable}, 32'h0);
    v = VECS[2]; v.addr = 32'h1234_5660; pulseFault(v);
    readReg(0, r); check("R8 no flag while off", r, 32'h4000_1050);
    readReg(5, r); check("R8 addr unchanged", r, 32'h4000_0000);
    writeReg(0, 32'h0000_0001);
    check("R8 protEnable high", {31'b0, protEnable}, 32'h1);
    pulseFault(v);
    readReg(5, r); check("R8 capture restored", r, 32'h1234_5660);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule